// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Error Reporting

This block receives asynchronous serial characters on a single input line. A one-cycle enable, `tick16`, marks each sub-bit period and runs at sixteen times the bit rate. A falling edge on the line starts a candidate frame. The receiver confirms the start bit at mid-bit and then samples every later bit at its centre. A character can have 7, 8 or 9 data bits, an optional odd or even parity bit and one or two stop bits. Each finished character is copied from the shift register into a one-entry receive buffer. The copy raises a one-cycle interrupt pulse and reports parity, framing and overrun errors, together with their OR as an error sum.

The buffer is presented as a valid/ready stream source. `out_valid` is high while an unread character is held. A read takes place in any cycle where `out_valid` and `out_ready` are both high. Back-pressure never stalls the line, because the line cannot be held off. If a new character finishes while the buffer is still unread, the new character overwrites the buffer, the overrun flag is set and no interrupt is raised. Two optional modes change the input. Polarity inversion complements the line before start detection. Data inversion complements only the data bits of a character. A sleep mode for multi-drop buses accepts only 9-bit characters whose top bit is set.

Top module: `serial_rx_errflag`

## Requirements
- R1: With `rx_en`=1, a low level in idle begins a start bit, which is accepted only if the line is still low at the 8th `tick16` after detection. A shorter low pulse returns the receiver to idle and produces no character.
- R2: While `rx_en`=0, activity on the line produces no character, no interrupt and no change of `out_valid`.
- R3: `cfg_len` selects 7 (0), 8 (1) or 9 (2) data bits. Data is received least significant bit first and presented right-aligned on `out_data`, with the unused upper bits zero. Each later bit is sampled 16 ticks after the previous sample.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `err_parity` is set when the number of ones in the data bits and the parity bit, as seen on the line, is odd while `cfg_par_odd`=0, or even while `cfg_par_odd`=1.
- R5: `cfg_two_stop` selects 1 (0) or 2 (1) stop bits. `err_framing` is set if any configured stop bit is sampled low.
- R6: An accepted character into an empty buffer sets `out_valid` and pulses `rx_irq` high for exactly one cycle, in the same cycle. After reset, `out_valid`, `rx_irq` and all error flags are 0.
- R7: An accepted character that finishes while `out_valid`=1 and no read takes place in that cycle overwrites `out_data` and sets `err_overrun`, and `rx_irq` stays low.
- R8: `err_sum` equals the OR of `err_overrun`, `err_framing` and `err_parity`.
- R9: Error flags are sticky: they are ORed with the errors of later characters until a read (`out_valid` and `out_ready` both high), which clears `out_valid` and every error flag.
- R10: With `cfg_rx_invert`=1, the line level is complemented before any detection, so idle is low and the start bit is high.
- R11: With `cfg_data_inv`=1, only the data bits are complemented in `out_data`. Parity is still evaluated on the bits as seen on the line, and stop bits are unaffected.
- R12: With `cfg_sleep`=1 and 9-bit characters, a character whose bit 8 is 0 is discarded: no buffer write, no flag change, no interrupt. A character with bit 8 set is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sub-bit enable, 16 per bit period |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial line input |
| cfg_len | input | 2 | Data length: 0=7, 1=8, 2=9 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_rx_invert | input | 1 | Complement the line level |
| cfg_data_inv | input | 1 | Complement received data bits |
| cfg_sleep | input | 1 | Multi-drop address filter |
| out_ready | input | 1 | Consumer reads the buffer |
| out_valid | output | 1 | Buffer holds an unread character |
| out_data | output | 9 | Received character, right-aligned |
| rx_irq | output | 1 | One-cycle receive-complete pulse |
| err_overrun | output | 1 | Overrun flag |
| err_framing | output | 1 | Framing flag |
| err_parity | output | 1 | Parity flag |
| err_sum | output | 1 | OR of the three error flags |

## Verification
The hardest case to reach is a character that finishes while an earlier character with its own error is still unread. In that case the flags must combine, the data must be replaced and the interrupt must stay silent. The stimulus sends a bad-parity character, holds `out_ready` low, and then sends a clean character. The scoreboard then expects overwritten data with both the parity and overrun flags set and no interrupt. Discarded and aborted frames produce no event at all. They are covered by checking `out_valid` through the stream interface right after the stimulus, and by checking at the end that the expectation queue is empty.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned MAX_BITS = 9;
  localparam int unsigned OSR      = 16;

  typedef enum logic [1:0] {LEN7 = 2'd0, LEN8 = 2'd1, LEN9 = 2'd2} char_len_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  function automatic logic [3:0] len_bits(input logic [1:0] len);
    case (len)
      LEN7:    return 4'd7;
      LEN8:    return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  function automatic logic [MAX_BITS-1:0] len_mask(input logic [1:0] len);
    case (len)
      LEN7:    return 9'h07F;
      LEN8:    return 9'h0FF;
      default: return 9'h1FF;
    endcase
  endfunction
endpackage

// File: rtl/rx_line_cond.sv
module rx_line_cond #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic invert,
  output logic line
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], rxd};
  end

  assign line = sync_q[STAGES-1] ^ invert;
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = OSR
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                en,
  input  logic                line,
  input  logic [1:0]          len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  output logic                done,
  output logic [MAX_BITS-1:0] raw_data,
  output logic                par_err,
  output logic                frm_err
);
  localparam int unsigned CW   = $clog2(OVERSAMPLE);
  localparam int unsigned HALF = OVERSAMPLE / 2;

  rx_state_e            state;
  logic [CW-1:0]        sub_cnt;
  logic [3:0]           bit_idx;
  logic [MAX_BITS-1:0]  shreg;
  logic                 par_acc;
  logic                 sample_pt;

  assign sample_pt = tick && (sub_cnt == CW'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sub_cnt <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      done    <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick && state != ST_IDLE) sub_cnt <= sample_pt ? '0 : sub_cnt + 1'b1;
      if (!en) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (tick && !line) begin
            state   <= ST_START;
            sub_cnt <= '0;
          end
          ST_START: if (tick && sub_cnt == CW'(HALF - 1)) begin
            sub_cnt <= '0;
            if (!line) begin
              state   <= ST_DATA;
              bit_idx <= '0;
              par_acc <= 1'b0;
              par_err <= 1'b0;
              frm_err <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_DATA: if (sample_pt) begin
            shreg   <= {line, shreg[MAX_BITS-1:1]};
            par_acc <= par_acc ^ line;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == len_bits(len) - 1'b1) state <= par_en ? ST_PAR : ST_STOP1;
          end
          ST_PAR: if (sample_pt) begin
            par_err <= (par_acc ^ line) != par_odd;
            state   <= ST_STOP1;
          end
          ST_STOP1: if (sample_pt) begin
            frm_err <= !line;
            if (two_stop) state <= ST_STOP2;
            else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
          ST_STOP2: if (sample_pt) begin
            frm_err <= frm_err | !line;
            state   <= ST_IDLE;
            done    <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (len)
      LEN7:    raw_data = {2'b00, shreg[MAX_BITS-1:2]};
      LEN8:    raw_data = {1'b0,  shreg[MAX_BITS-1:1]};
      default: raw_data = shreg;
    endcase
  end
endmodule

// File: rtl/rx_holdbuf.sv
module rx_holdbuf #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         wr_fe,
  input  logic         wr_pe,
  input  logic         rd,
  output logic [W-1:0] data,
  output logic         valid,
  output logic         ov,
  output logic         fe,
  output logic         pe,
  output logic         sum,
  output logic         irq
);
  logic ov_new, keep_ov, keep_fe, keep_pe, keep_sum;

  assign ov_new   = wr && valid && !rd;
  assign keep_ov  = ov  && !rd;
  assign keep_fe  = fe  && !rd;
  assign keep_pe  = pe  && !rd;
  assign keep_sum = sum && !rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
      ov    <= 1'b0;
      fe    <= 1'b0;
      pe    <= 1'b0;
      sum   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= wr && !ov_new;
      if (wr) data <= wr_data;
      valid <= wr || (valid && !rd);
      ov    <= keep_ov  | ov_new;
      fe    <= keep_fe  | (wr && wr_fe);
      pe    <= keep_pe  | (wr && wr_pe);
      sum   <= keep_sum | ov_new | (wr && (wr_fe || wr_pe));
    end
  end
endmodule

// File: rtl/serial_rx_errflag.sv
module serial_rx_errflag
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_en,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       cfg_rx_invert,
  input  logic       cfg_data_inv,
  input  logic       cfg_sleep,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [8:0] out_data,
  output logic       rx_irq,
  output logic       err_overrun,
  output logic       err_framing,
  output logic       err_parity,
  output logic       err_sum
);
  logic                line, f_done, f_pe, f_fe, accept;
  logic [MAX_BITS-1:0] f_raw, rx_char;

  rx_line_cond #(.STAGES(2)) u_cond (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .invert(cfg_rx_invert), .line(line)
  );

  rx_framer #(.OVERSAMPLE(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .en(rx_en), .line(line),
    .len(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .two_stop(cfg_two_stop), .done(f_done), .raw_data(f_raw),
    .par_err(f_pe), .frm_err(f_fe)
  );

  assign rx_char = f_raw ^ (cfg_data_inv ? len_mask(cfg_len) : '0);
  assign accept  = f_done && !(cfg_sleep && cfg_len == LEN9 && !rx_char[MAX_BITS-1]);

  rx_holdbuf #(.W(MAX_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(accept), .wr_data(rx_char),
    .wr_fe(f_fe), .wr_pe(f_pe), .rd(out_valid && out_ready),
    .data(out_data), .valid(out_valid), .ov(err_overrun), .fe(err_framing),
    .pe(err_parity), .sum(err_sum), .irq(rx_irq)
  );
endmodule

// File: rtl/serial_rx_errflag_chk.sv
module serial_rx_errflag_chk (
  input logic clk,
  input logic rst_n,
  input logic out_valid,
  input logic out_ready,
  input logic rx_irq,
  input logic err_overrun,
  input logic err_framing,
  input logic err_parity,
  input logic err_sum
);
  // R6
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  // R6
  irq_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> out_valid);
  // R7
  overrun_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> !rx_irq);
  // R8
  sum_is_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sum == (err_overrun | err_framing | err_parity));
  // R9
  read_clears_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !err_overrun);
  // R9
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sum |-> out_valid);
endmodule

bind serial_rx_errflag serial_rx_errflag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .rx_irq(rx_irq), .err_overrun(err_overrun), .err_framing(err_framing),
  .err_parity(err_parity), .err_sum(err_sum)
);

// File: tb/serial_rx_errflag_test.sv
`timescale 1ns/1ps
module serial_rx_errflag_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, tick16 = 1'b1, rx_en = 1'b1, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd1;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic cfg_rx_invert = 0, cfg_data_inv = 0, cfg_sleep = 0, out_ready = 0;
  logic out_valid, rx_irq, err_overrun, err_framing, err_parity, err_sum;
  logic [8:0] out_data;

  serial_rx_errflag uut (.*);

  typedef struct { logic [8:0] d; logic ov, fe, pe; string req; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input logic [8:0] d, input logic ov, fe, pe, input string req);
    exp_t e;
    e.d = d; e.ov = ov; e.fe = fe; e.pe = pe; e.req = req;
    q.push_back(e);
  endtask

  // driver: sends character c in the current configuration
  task automatic send_char(input logic [8:0] c, input bit bad_par, input bit bad_stop2);
    int nb;
    logic [8:0] mask, ld;
    logic p;
    logic [13:0] bits;
    int n;
    nb   = (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd1) ? 8 : 9;
    mask = (9'h1FF >> (9 - nb));
    ld   = (cfg_data_inv ? ~c : c) & mask;
    p    = ($countones(ld) % 2 == 1) ^ cfg_par_odd ^ bad_par;
    n = 0;
    bits[n++] = 1'b0;
    for (int i = 0; i < nb; i++) bits[n++] = ld[i];
    if (cfg_par_en) bits[n++] = p;
    bits[n++] = 1'b1;
    if (cfg_two_stop) bits[n++] = !bad_stop2;
    for (int i = 0; i < n; i++) begin
      rxd = bits[i] ^ cfg_rx_invert;
      repeat (16) @(negedge clk);
    end
    rxd = cfg_rx_invert;
    rxd = ~rxd;
    repeat (40) @(negedge clk);
  endtask

  task automatic do_read(input string req);
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
    check(!out_valid && !err_sum && !err_overrun && !err_framing && !err_parity, req,
          {out_valid, err_overrun, err_framing, err_parity, err_sum}, 0);
  endtask

  // monitor / scoreboard
  logic [12:0] prev = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_irq || (out_valid && {out_data, err_overrun, err_framing, err_parity} != prev)) begin
        if (q.size() == 0) begin
          check(0, "unexpected character event R2", {23'd0, out_data}, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_data == e.d, {e.req, " data"}, {23'd0, out_data}, {23'd0, e.d});
          check({err_overrun, err_framing, err_parity} == {e.ov, e.fe, e.pe}, {e.req, " flags"},
                {29'd0, err_overrun, err_framing, err_parity}, {29'd0, e.ov, e.fe, e.pe});
          check(err_sum == (e.ov | e.fe | e.pe), {e.req, " sum R8"}, {31'd0, err_sum}, {31'd0, e.ov | e.fe | e.pe});
          check(rx_irq == !e.ov, {e.req, " irq R6/R7"}, {31'd0, rx_irq}, {31'd0, !e.ov});
        end
      end
      prev <= {out_data, err_overrun, err_framing, err_parity};
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6 reset state
    check(!out_valid && !rx_irq && !err_sum && !err_overrun, "R6 reset", {30'd0, out_valid, err_sum}, 0);

    // R3 lengths
    expect_item(9'h05A, 0, 0, 0, "R3 8-bit");  send_char(9'h05A, 0, 0); do_read("R9 read");
    cfg_len = 2'd0;
    expect_item(9'h035, 0, 0, 0, "R3 7-bit");  send_char(9'h035, 0, 0); do_read("R9 read");
    cfg_len = 2'd2;
    expect_item(9'h1C3, 0, 0, 0, "R3 9-bit");  send_char(9'h1C3, 0, 0); do_read("R9 read");
    cfg_len = 2'd1;

    // R4 parity
    cfg_par_en = 1;
    expect_item(9'h096, 0, 0, 0, "R4 even ok"); send_char(9'h096, 0, 0); do_read("R9 read");
    cfg_par_odd = 1;
    expect_item(9'h001, 0, 0, 0, "R4 odd ok");  send_char(9'h001, 0, 0); do_read("R9 read");
    expect_item(9'h0E7, 0, 0, 1, "R4 odd bad"); send_char(9'h0E7, 1, 0); do_read("R9 clears pe");
    cfg_par_en = 0; cfg_par_odd = 0;

    // R5 stop bits
    cfg_two_stop = 1;
    expect_item(9'h03C, 0, 0, 0, "R5 two ok");  send_char(9'h03C, 0, 0); do_read("R9 read");
    expect_item(9'h0C3, 0, 1, 0, "R5 framing"); send_char(9'h0C3, 0, 1); do_read("R9 clears fe");
    cfg_two_stop = 0;

    // R7 overrun with sticky R9 parity flag
    cfg_par_en = 1;
    expect_item(9'h011, 0, 0, 1, "R7 first");   send_char(9'h011, 1, 0);
    expect_item(9'h022, 1, 0, 1, "R7 overrun R9 sticky"); send_char(9'h022, 0, 0);
    do_read("R9 clears ov");
    cfg_par_en = 0;

    // R10 polarity inversion
    cfg_rx_invert = 1; rxd = 1'b0; repeat (20) @(negedge clk);
    expect_item(9'h0A3, 0, 0, 0, "R10 invert"); send_char(9'h0A3, 0, 0); do_read("R9 read");
    cfg_rx_invert = 0; rxd = 1'b1; repeat (20) @(negedge clk);

    // R11 data inversion, even parity on line bits
    cfg_data_inv = 1; cfg_par_en = 1;
    expect_item(9'h0C4, 0, 0, 0, "R11 data inv"); send_char(9'h0C4, 0, 0); do_read("R9 read");
    cfg_data_inv = 0; cfg_par_en = 0;

    // R12 sleep filter
    cfg_sleep = 1; cfg_len = 2'd2;
    send_char(9'h0A5, 0, 0);
    check(!out_valid, "R12 discard", {31'd0, out_valid}, 0);
    expect_item(9'h1A5, 0, 0, 0, "R12 address"); send_char(9'h1A5, 0, 0); do_read("R9 read");
    cfg_sleep = 0; cfg_len = 2'd1;

    // R1 false start
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    check(!out_valid, "R1 false start", {31'd0, out_valid}, 0);

    // R2 disabled
    rx_en = 0;
    send_char(9'h077, 0, 0);
    check(!out_valid, "R2 disabled", {31'd0, out_valid}, 0);
    rx_en = 1;
    repeat (20) @(negedge clk);

    check(q.size() == 0, "R3 all expected seen", q.size(), 0);
    finish_run();
  end
endmodule